// File: doc/BRIEF.md
# LCD Frame Pulse Generator

This block makes the once-per-frame vertical sync pulse for an LCD panel controller. It counts line strobes inside a frame. A frame is made of the visible lines followed by a vertical non-display period. The pulse is placed inside that non-display period, and its start offset, length in lines and polarity are all programmable. Two kinds of panel are supported: active-matrix (TFT) and passive. A single polarity bit means opposite things on the two kinds. The programmed length takes effect only on TFT panels; on a passive panel the pulse is always one line long.

Frame geometry and the pulse controls are captured at the start of every frame, so a register write never shortens or stretches a pulse that is already under way. The block also gates the pixel data path with a blank control. It flags TFT settings that do not fit in the non-display period, and it gives back the control byte with its unused bits forced to zero.

Top module: `lcd_frame_pulse`

## Requirements
- R1: The asserted level of `frame_pulse` is `pol` on a TFT panel and `~pol` on a passive panel, where `pol` is `ctrl_byte[7]`. The idle level is always the opposite of the asserted level.
- R2: On a TFT panel, counting lines from 0 at frame start, the pulse is asserted on lines `disp_height + pulse_start` through `disp_height + pulse_start + ctrl_byte[2:0]`, inclusive. That is `ctrl_byte[2:0] + 1` lines, anywhere from 1 to 8.
- R3: On a passive panel the pulse is asserted on line `disp_height` only. The width field and `pulse_start` are ignored.
- R4: `cfg_err` is 1 exactly when `panel_tft` is 1 and `(vnd_len + 1) < (pulse_start + 1) + (ctrl_byte[2:0] + 1)`. It is evaluated combinationally from the live inputs and is never 1 on a passive panel.
- R5: `pix_out` is registered. One clock after `blank` is 1 it is all zeros; one clock after `blank` is 0 it equals the previous cycle's `pix_in`.
- R6: `ctrl_rd` returns `ctrl_byte` with bit 7 and bits 2:0 kept and bits 6:3 reading as zero.
- R7: A frame lasts `disp_height + vnd_len + 1` line strobes. The strobe that arrives on the last line returns the line index to 0, which starts a new frame.
- R8: Panel type, polarity, width, start, height and non-display length are captured only at reset and at frame start. A change during a frame has no effect on `frame_pulse` until the next frame.
- R9: During and right after reset the line index is 0, `frame_pulse` is at the idle level for the settings on the inputs at reset, and `pix_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_stb | input | 1 | One-cycle strobe per display line |
| panel_tft | input | 1 | 1 = TFT panel, 0 = passive panel |
| ctrl_byte | input | 8 | Bit 7 polarity select, bits 2:0 pulse width minus one |
| disp_height | input | 10 | Number of visible lines |
| vnd_len | input | 6 | Non-display lines minus one |
| pulse_start | input | 8 | Pulse offset in lines from the first non-display line |
| blank | input | 1 | 1 forces pixel output to zero |
| pix_in | input | PIX_W | Pixel data from the display pipeline |
| frame_pulse | output | 1 | Frame sync pulse |
| cfg_err | output | 1 | TFT pulse settings do not fit in the non-display period |
| ctrl_rd | output | 8 | Control byte with bits 6:3 forced to zero |
| pix_out | output | PIX_W | Gated pixel data |

## Verification
The bench steps through whole frames on both panel types and under both polarity settings, and compares every line against its own line model. A design that swapped the polarity sense for one panel type would invert the whole waveform. A design that applied the width on passive panels would hold the pulse too long. To show that settings are captured per frame, panel type, width and polarity are changed in the middle of a frame: a design that read them live would change the pulse before the frame boundary. The `cfg_err` test sits exactly on the boundary of the fit rule, where an off-by-one error in the comparison would flag a legal setting.

// File: rtl/lcd_fp_pkg.sv
package lcd_fp_pkg;

    localparam int FP_H_W   = 10;
    localparam int FP_V_W   = 6;
    localparam int FP_S_W   = 8;
    localparam int FP_WID_W = 3;
    localparam int FP_CNT_W = FP_H_W + 2;

    typedef struct packed {
        logic                tft;
        logic                pol;
        logic [FP_WID_W-1:0] wid;
        logic [FP_S_W-1:0]   start;
        logic [FP_H_W-1:0]   height;
        logic [FP_V_W-1:0]   vnd;
    } frame_cfg_t;

    // Level the pulse takes while asserted.
    function automatic logic on_level(input logic tft, input logic pol);
        return tft ? pol : ~pol;
    endfunction

    // Pulse start plus width must fit in the non-display period.
    function automatic logic cfg_fits(input logic [FP_V_W-1:0]   v,
                                      input logic [FP_S_W-1:0]   s,
                                      input logic [FP_WID_W-1:0] w);
        int lhs;
        int rhs;
        lhs = int'(v) + 1;
        rhs = (int'(s) + 1) + (int'(w) + 1);
        return lhs >= rhs;
    endfunction

    function automatic logic [7:0] ctrl_view(input logic [7:0] b);
        return {b[7], 4'b0000, b[2:0]};
    endfunction

endpackage

// File: rtl/fp_line_counter.sv
module fp_line_counter
    import lcd_fp_pkg::*;
#(
    parameter int CNT_W = FP_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_stb,
    input  frame_cfg_t       cfg_in,
    output frame_cfg_t       cfg_q,
    output logic [CNT_W-1:0] line_q,
    output logic [CNT_W-1:0] last_line
);

    assign last_line = CNT_W'(cfg_q.height) + CNT_W'(cfg_q.vnd);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= cfg_in;
            line_q <= '0;
        end else if (line_stb) begin
            if (line_q == last_line) begin
                line_q <= '0;
                cfg_q  <= cfg_in;
            end else begin
                line_q <= line_q + 1'b1;
            end
        end
    end

    assert_line_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
        line_q <= last_line);

    assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (line_stb && line_q == last_line) |=> line_q == '0);

    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (rst)
        !line_stb |=> $stable(cfg_q) && $stable(line_q));

endmodule

// File: rtl/fp_pulse_window.sv
module fp_pulse_window
    import lcd_fp_pkg::*;
#(
    parameter int CNT_W = FP_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_cfg_t       cfg,
    input  logic [CNT_W-1:0] line_q,
    output logic             active
);

    logic [CNT_W-1:0] first_line;
    logic [CNT_W-1:0] final_line;
    logic             tft_hit;
    logic             psv_hit;

    always_comb begin
        first_line = CNT_W'(cfg.height) + CNT_W'(cfg.start);
        final_line = first_line + CNT_W'(cfg.wid);
        tft_hit    = (line_q >= first_line) && (line_q <= final_line);
        psv_hit    = (line_q == CNT_W'(cfg.height));
        active     = cfg.tft ? tft_hit : psv_hit;
    end

    assert_tft_start_line_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(active) && cfg.tft) |-> line_q == CNT_W'(cfg.height) + CNT_W'(cfg.start));

    assert_passive_on_height_R3: assert property (@(posedge clk) disable iff (rst)
        (active && !cfg.tft) |-> line_q == CNT_W'(cfg.height));

endmodule

// File: rtl/fp_blank_gate.sv
module fp_blank_gate #(
    parameter int PIX_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blank,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pix_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out <= '0;
        end else if (blank) begin
            pix_out <= '0;
        end else begin
            pix_out <= pix_in;
        end
    end

    assert_blank_zero_R5: assert property (@(posedge clk) disable iff (rst)
        blank |=> pix_out == '0);

endmodule

// File: rtl/lcd_frame_pulse.sv
module lcd_frame_pulse
    import lcd_fp_pkg::*;
#(
    parameter int PIX_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_stb,
    input  logic                panel_tft,
    input  logic [7:0]          ctrl_byte,
    input  logic [FP_H_W-1:0]   disp_height,
    input  logic [FP_V_W-1:0]   vnd_len,
    input  logic [FP_S_W-1:0]   pulse_start,
    input  logic                blank,
    input  logic [PIX_W-1:0]    pix_in,
    output logic                frame_pulse,
    output logic                cfg_err,
    output logic [7:0]          ctrl_rd,
    output logic [PIX_W-1:0]    pix_out
);

    localparam int CNT_W = FP_CNT_W;

    frame_cfg_t       cfg_live;
    frame_cfg_t       cfg_q;
    logic [CNT_W-1:0] line_q;
    logic [CNT_W-1:0] last_line;
    logic             active;

    always_comb begin
        cfg_live.tft    = panel_tft;
        cfg_live.pol    = ctrl_byte[7];
        cfg_live.wid    = ctrl_byte[FP_WID_W-1:0];
        cfg_live.start  = pulse_start;
        cfg_live.height = disp_height;
        cfg_live.vnd    = vnd_len;
    end

    fp_line_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .line_stb  (line_stb),
        .cfg_in    (cfg_live),
        .cfg_q     (cfg_q),
        .line_q    (line_q),
        .last_line (last_line)
    );

    fp_pulse_window #(.CNT_W(CNT_W)) u_window (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg_q),
        .line_q (line_q),
        .active (active)
    );

    fp_blank_gate #(.PIX_W(PIX_W)) u_blank (
        .clk     (clk),
        .rst     (rst),
        .blank   (blank),
        .pix_in  (pix_in),
        .pix_out (pix_out)
    );

    assign frame_pulse = active ? on_level(cfg_q.tft, cfg_q.pol)
                                : ~on_level(cfg_q.tft, cfg_q.pol);
    assign cfg_err     = panel_tft && !cfg_fits(vnd_len, pulse_start, ctrl_byte[FP_WID_W-1:0]);
    assign ctrl_rd     = ctrl_view(ctrl_byte);

    // Passive pulse lasts one line when the next line stays in the same frame.
    assert_passive_one_line_R3: assert property (@(posedge clk) disable iff (rst)
        (active && !cfg_q.tft && line_stb && cfg_q.vnd != '0) |=> !active);

    assert_err_tft_only_R4: assert property (@(posedge clk) disable iff (rst)
        !panel_tft |-> !cfg_err);

    assert_line_at_zero_after_reset_R9: assert property (@(posedge clk)
        $fell(rst) |-> line_q == '0);

endmodule

// File: tb/test_lcd_frame_pulse.sv
`timescale 1ns/1ps
module test_lcd_frame_pulse;

    localparam int PIX_W = 18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              line_stb = 1'b0;
    logic              panel_tft = 1'b1;
    logic [7:0]        ctrl_byte = 8'h82;
    logic [9:0]        disp_height = 10'd4;
    logic [5:0]        vnd_len = 6'd5;
    logic [7:0]        pulse_start = 8'd1;
    logic              blank = 1'b1;
    logic [PIX_W-1:0]  pix_in = '0;
    logic              frame_pulse;
    logic              cfg_err;
    logic [7:0]        ctrl_rd;
    logic [PIX_W-1:0]  pix_out;

    int checks = 0;
    int errors = 0;

    // model state
    int m_line;
    int m_h, m_v, m_s, m_w;
    logic m_pol, m_tft;

    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    lcd_frame_pulse #(.PIX_W(PIX_W)) i_lcd_frame_pulse (
        .clk(clk), .rst(rst), .line_stb(line_stb), .panel_tft(panel_tft),
        .ctrl_byte(ctrl_byte), .disp_height(disp_height), .vnd_len(vnd_len),
        .pulse_start(pulse_start), .blank(blank), .pix_in(pix_in),
        .frame_pulse(frame_pulse), .cfg_err(cfg_err), .ctrl_rd(ctrl_rd),
        .pix_out(pix_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic on_lvl(input logic tft, input logic pol);
        return tft ? pol : ~pol;
    endfunction

    function automatic logic exp_level();
        logic act;
        if (m_tft) act = (m_line >= m_h + m_s) && (m_line <= m_h + m_s + m_w);
        else       act = (m_line == m_h);
        return act ? on_lvl(m_tft, m_pol) : ~on_lvl(m_tft, m_pol);
    endfunction

    task automatic capture();
        m_h = int'(disp_height); m_v = int'(vnd_len); m_s = int'(pulse_start);
        m_w = int'(ctrl_byte[2:0]); m_pol = ctrl_byte[7]; m_tft = panel_tft;
    endtask

    // driver: one line strobe, expected level pushed to the scoreboard
    task automatic line_step();
        string t;
        @(negedge clk);
        line_stb = 1'b1;
        if (m_line == m_h + m_v) begin
            m_line = 0;
            capture();
            t = "R7";
        end else begin
            m_line++;
            if (m_tft != panel_tft || m_pol != ctrl_byte[7] || m_w != int'(ctrl_byte[2:0]))
                t = "R8";
            else
                t = m_tft ? "R2" : "R3";
        end
        exp_q.push_back(exp_level());
        tag_q.push_back(t);
        @(negedge clk);
        line_stb = 1'b0;
    endtask

    // monitor: compare design output with scoreboard after each strobe edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'(frame_pulse), 32'(e));
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        capture();
        m_line = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: during reset, idle level for TFT active high is 0
        check("R9", 32'(frame_pulse), 32'(1'b0));
        check("R9", 32'(pix_out), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R9", 32'(frame_pulse), 32'(1'b0));
        check("R9", 32'(pix_out), 32'h0);

        // R4: boundary of fit rule, V=5 -> 6 lines
        check("R4", 32'(cfg_err), 32'(1'b0));
        pulse_start = 8'd2; #1;
        check("R4", 32'(cfg_err), 32'(1'b0));
        pulse_start = 8'd3; #1;
        check("R4", 32'(cfg_err), 32'(1'b1));
        panel_tft = 1'b0; pulse_start = 8'd7; #1;
        check("R4", 32'(cfg_err), 32'(1'b0));
        panel_tft = 1'b1; pulse_start = 8'd1; #1;

        // R6: control readback masks bits 6:3
        ctrl_byte = 8'hFF; #1;
        check("R6", 32'(ctrl_rd), 32'h87);
        ctrl_byte = 8'h78; #1;
        check("R6", 32'(ctrl_rd), 32'h00);
        ctrl_byte = 8'h82; #1;

        // R5: blank gating
        @(negedge clk);
        blank = 1'b1; pix_in = 18'h2AAAA;
        @(negedge clk);
        check("R5", 32'(pix_out), 32'h0);
        blank = 1'b0; pix_in = 18'h15555;
        @(negedge clk);
        check("R5", 32'(pix_out), 32'h15555);
        pix_in = 18'h00F0F;
        @(negedge clk);
        check("R5", 32'(pix_out), 32'h00F0F);

        // R2 / R7: two TFT frames, active high, width 3 lines
        for (int i = 0; i < 20; i++) line_step();

        // R8: switch to passive with width 7 mid-frame; current frame stays TFT
        for (int i = 0; i < 3; i++) line_step();
        panel_tft = 1'b0; ctrl_byte = 8'h87; pulse_start = 8'd5;
        for (int i = 0; i < 17; i++) line_step();

        // R1 / R3: passive, polarity 1 -> active low; then polarity 0 mid-frame
        for (int i = 0; i < 4; i++) line_step();
        ctrl_byte = 8'h07;
        for (int i = 0; i < 16; i++) line_step();

        // R1 / R2: TFT polarity 0 -> active low, one-line width, zero start
        panel_tft = 1'b1; ctrl_byte = 8'h00; pulse_start = 8'd0;
        disp_height = 10'd2; vnd_len = 6'd3;
        for (int i = 0; i < 22; i++) line_step();

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule